// File: doc/BRIEF.md
# Sleep Mode Sequencer

This block sequences a synchronous memory into and out of a low-power sleep state. The sleep request arrives asynchronously and is active high. It is first passed through a synchronizer chain. A small state machine then walks through four phases: awake, entering, asleep and recovering. The entry phase and the recovery phase each last a fixed number of clock cycles, two by default.

While the machine is in any phase other than awake, the access-allowed output is low and the data outputs are held in high impedance. This gates the memory's access logic and leaves the stored contents untouched. The sleep-active output is high only in the asleep phase.

The select/strobe input reports a device select or address strobe. If it is seen during entry or recovery, the block ignores that access and raises a sticky error flag. Only reset clears the flag. A select seen while fully asleep is dropped without an error, in the same way as an access that was pending at entry.

Top module: `sleep_sequencer`

## Requirements
- R1: After reset, accessOk is 1, sleepActive is 0, outHiZ is 0 and errFlag is 0.
- R2: A request that rises and stays high is seen through SYNC_STAGES (2) flops. accessOk falls and outHiZ rises at the third rising edge after the request goes high, which starts the entry phase.
- R3: The entry phase lasts exactly ENTRY_CYCLES (2) cycles. sleepActive rises two edges after accessOk fell.
- R4: While asleep, sleepActive is 1, accessOk is 0 and outHiZ is 1. A select/strobe in this phase has no effect and sets no error.
- R5: When the request falls, sleepActive falls at the third rising edge after the fall. accessOk stays 0 and outHiZ stays 1, which starts the recovery phase.
- R6: The recovery phase lasts exactly RECOVERY_CYCLES (2) cycles. accessOk then returns to 1 and outHiZ to 0. The block never goes straight from asleep to awake.
- R7: A select/strobe seen in the entry or recovery phase sets errFlag at the next edge. The flag stays set until reset, and the timing of the sequence does not change.
- R8: A select/strobe while awake, with no request, sets no error and leaves accessOk at 1.
- R9: An entry that has started always completes into the asleep phase, even if the request has dropped. A request that rises again during recovery lets recovery finish, gives exactly one awake cycle, and then starts a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sleepReq | input | 1 | Asynchronous sleep request, active high |
| selActive | input | 1 | Device select or address strobe seen this cycle |
| sleepActive | output | 1 | High while in the asleep phase |
| accessOk | output | 1 | High only while awake; gates access logic |
| outHiZ | output | 1 | High when the data outputs must be high impedance |
| errFlag | output | 1 | Sticky flag for a select/strobe during entry or recovery |

## Verification
The request crosses two synchronizer flops and then the state register. A change on sleepReq therefore shows on accessOk or sleepActive at the third rising edge, and the phase after that lasts two more edges. An error shows one edge after the offending select/strobe. The bench drives every input at a falling edge and steps a counted number of rising edges before sampling at the next falling edge. Each check therefore sits in the exact cycle these latencies give, including the cycle just before each change, where the old value must still hold.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE   = 2'd0,
    ST_ENTER   = 2'd1,
    ST_ASLEEP  = 2'd2,
    ST_RECOVER = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;  // restart the phase counter
    logic cntInc;  // advance the phase counter
    logic limSel;  // 0: entry length, 1: recovery length
    logic errSet;  // set the sticky error flag
  } seqStrobe_t;

endpackage

// File: rtl/sleep_seq_dp.sv
module sleep_seq_dp
  import sleep_seq_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int ENTRY_CYCLES    = 2,
  parameter int RECOVERY_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  seqStrobe_t strobe,
  output logic       reqSync,
  output logic       cntDone,
  output logic       errFlag
);

  localparam int MAX_LEN = (ENTRY_CYCLES > RECOVERY_CYCLES) ? ENTRY_CYCLES : RECOVERY_CYCLES;
  localparam int CNT_W   = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);
  localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] REC_LAST   = CNT_W'(RECOVERY_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       phaseCnt;

  generate
    if (SYNC_STAGES == 1) begin : g_syncSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= sleepReq;
      end
    end else begin : g_syncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sleepReq};
      end
    end
  endgenerate

  assign reqSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phaseCnt <= '0;
    else if (strobe.cntClr) phaseCnt <= '0;
    else if (strobe.cntInc) phaseCnt <= phaseCnt + 1'b1;
  end

  assign cntDone = (phaseCnt == (strobe.limSel ? REC_LAST : ENTRY_LAST));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              errFlag <= 1'b0;
    else if (strobe.errSet) errFlag <= 1'b1;
  end

endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqSync,
  input  logic       cntDone,
  input  logic       selActive,
  output seqState_t  state,
  output seqStrobe_t strobe
);

  seqState_t nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_AWAKE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_AWAKE: begin
        strobe.cntClr = 1'b1;
        if (reqSync) nextState = ST_ENTER;
      end
      ST_ENTER: begin
        strobe.errSet = selActive;
        strobe.limSel = 1'b0;
        if (cntDone) begin
          strobe.cntClr = 1'b1;
          nextState     = ST_ASLEEP;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_ASLEEP: begin
        strobe.cntClr = 1'b1;
        if (!reqSync) nextState = ST_RECOVER;
      end
      ST_RECOVER: begin
        strobe.errSet = selActive;
        strobe.limSel = 1'b1;
        if (cntDone) begin
          strobe.cntClr = 1'b1;
          nextState     = ST_AWAKE;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      default: nextState = ST_AWAKE;
    endcase
  end

endmodule

// File: rtl/sleep_sequencer.sv
module sleep_sequencer
  import sleep_seq_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int ENTRY_CYCLES    = 2,
  parameter int RECOVERY_CYCLES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReq,
  input  logic selActive,
  output logic sleepActive,
  output logic accessOk,
  output logic outHiZ,
  output logic errFlag
);

  seqState_t  state;
  seqStrobe_t strobe;
  logic       reqSync;
  logic       cntDone;

  sleep_seq_dp #(
    .SYNC_STAGES    (SYNC_STAGES),
    .ENTRY_CYCLES   (ENTRY_CYCLES),
    .RECOVERY_CYCLES(RECOVERY_CYCLES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sleepReq(sleepReq),
    .strobe  (strobe),
    .reqSync (reqSync),
    .cntDone (cntDone),
    .errFlag (errFlag)
  );

  sleep_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqSync  (reqSync),
    .cntDone  (cntDone),
    .selActive(selActive),
    .state    (state),
    .strobe   (strobe)
  );

  assign sleepActive = (state == ST_ASLEEP);
  assign accessOk    = (state == ST_AWAKE);
  assign outHiZ      = (state != ST_AWAKE);

endmodule

// File: rtl/sleep_sequencer_chk.sv
module sleep_sequencer_chk #(
  parameter int ENTRY_CYCLES    = 2,
  parameter int RECOVERY_CYCLES = 2
) (
  input logic clk,
  input logic rstN,
  input logic selActive,
  input logic sleepActive,
  input logic accessOk,
  input logic outHiZ,
  input logic errFlag
);

  // cycles spent in a transition phase (neither awake nor asleep)
  logic [15:0] gapCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        gapCnt <= '0;
    else if (!accessOk && !sleepActive) gapCnt <= (gapCnt == 16'hFFFF) ? gapCnt : gapCnt + 1'b1;
    else                              gapCnt <= '0;
  end

  AST_ENTRY_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepActive) |-> gapCnt == 16'(ENTRY_CYCLES)); // R3

  AST_RECOVERY_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accessOk) |-> gapCnt == 16'(RECOVERY_CYCLES)); // R6

  AST_WAKE_VIA_RECOVERY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepActive) |-> !accessOk); // R5

  AST_SLEEP_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    sleepActive |-> outHiZ && !accessOk); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R7

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(selActive && !accessOk && !sleepActive)); // R7

endmodule

bind sleep_sequencer sleep_sequencer_chk #(
  .ENTRY_CYCLES   (ENTRY_CYCLES),
  .RECOVERY_CYCLES(RECOVERY_CYCLES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .selActive  (selActive),
  .sleepActive(sleepActive),
  .accessOk   (accessOk),
  .outHiZ     (outHiZ),
  .errFlag    (errFlag)
);

// File: tb/tb_sleep_sequencer.sv
`timescale 1ns/1ps
module tb_sleep_sequencer;

  logic clk = 1'b0;
  logic rstN;
  logic sleepReq;
  logic selActive;
  logic sleepActive, accessOk, outHiZ, errFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sleep_sequencer dut (
    .clk        (clk),
    .rstN       (rstN),
    .sleepReq   (sleepReq),
    .selActive  (selActive),
    .sleepActive(sleepActive),
    .accessOk   (accessOk),
    .outHiZ     (outHiZ),
    .errFlag    (errFlag)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // advance n rising edges, return at the following falling edge
  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; sleepReq = 1'b0; selActive = 1'b0;
    step(3);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 accessOk", accessOk, 1'b1);
    chk("R1 sleepActive", sleepActive, 1'b0);
    chk("R1 outHiZ", outHiZ, 1'b0);
    chk("R1 errFlag", errFlag, 1'b0);
  endtask

  task automatic t_enter();
    sleepReq = 1'b1;
    step(2);
    chk("R2 accessOk before edge 3", accessOk, 1'b1);
    step(1);
    chk("R2 accessOk edge 3", accessOk, 1'b0);
    chk("R2 outHiZ edge 3", outHiZ, 1'b1);
    chk("R3 sleepActive entry cycle 1", sleepActive, 1'b0);
    step(1);
    chk("R3 sleepActive entry cycle 2", sleepActive, 1'b0);
    step(1);
    chk("R3 sleepActive after entry", sleepActive, 1'b1);
    chk("R4 outHiZ asleep", outHiZ, 1'b1);
    chk("R4 accessOk asleep", accessOk, 1'b0);
  endtask

  task automatic t_asleepIgnore();
    selActive = 1'b1;
    step(3);
    selActive = 1'b0;
    step(1);
    chk("R4 errFlag after select asleep", errFlag, 1'b0);
    chk("R4 sleepActive kept", sleepActive, 1'b1);
  endtask

  task automatic t_exit();
    sleepReq = 1'b0;
    step(2);
    chk("R5 sleepActive before edge 3", sleepActive, 1'b1);
    step(1);
    chk("R5 sleepActive edge 3", sleepActive, 1'b0);
    chk("R5 accessOk in recovery", accessOk, 1'b0);
    chk("R5 outHiZ in recovery", outHiZ, 1'b1);
    step(1);
    chk("R6 accessOk recovery cycle 2", accessOk, 1'b0);
    step(1);
    chk("R6 accessOk after recovery", accessOk, 1'b1);
    chk("R6 outHiZ after recovery", outHiZ, 1'b0);
    chk("R6 errFlag clean", errFlag, 1'b0);
  endtask

  task automatic t_awakeSelect();
    selActive = 1'b1;
    step(4);
    selActive = 1'b0;
    step(1);
    chk("R8 errFlag awake select", errFlag, 1'b0);
    chk("R8 accessOk awake select", accessOk, 1'b1);
  endtask

  task automatic t_entryErr();
    sleepReq = 1'b1;
    step(3);
    selActive = 1'b1;
    step(1);
    selActive = 1'b0;
    chk("R7 errFlag entry select", errFlag, 1'b1);
    step(1);
    chk("R7 entry timing unchanged", sleepActive, 1'b1);
    sleepReq = 1'b0;
    step(5);
    chk("R7 errFlag sticky after wake", errFlag, 1'b1);
    chk("R7 awake after error", accessOk, 1'b1);
    doReset();
    chk("R1 errFlag cleared by reset", errFlag, 1'b0);
  endtask

  task automatic t_recoveryErr();
    sleepReq = 1'b1;
    step(5);
    sleepReq = 1'b0;
    step(3);
    selActive = 1'b1;
    step(1);
    selActive = 1'b0;
    chk("R7 errFlag recovery select", errFlag, 1'b1);
    chk("R7 still recovering", accessOk, 1'b0);
    step(1);
    chk("R7 recovery timing unchanged", accessOk, 1'b1);
    doReset();
  endtask

  task automatic t_shortPulse();
    sleepReq = 1'b1;
    step(1);
    sleepReq = 1'b0;
    step(2);
    chk("R9 short pulse starts entry", accessOk, 1'b0);
    step(2);
    chk("R9 entry completes to asleep", sleepActive, 1'b1);
    step(1);
    chk("R9 leaves sleep after entry", sleepActive, 1'b0);
    step(1);
    chk("R9 recovery still held", accessOk, 1'b0);
    step(1);
    chk("R9 awake after short pulse", accessOk, 1'b1);
  endtask

  task automatic t_reRequest();
    sleepReq = 1'b1;
    step(5);
    sleepReq = 1'b0;
    step(3);
    sleepReq = 1'b1;
    step(1);
    chk("R9 recovery continues", accessOk, 1'b0);
    step(1);
    chk("R9 single awake cycle", accessOk, 1'b1);
    step(1);
    chk("R9 re-entry starts", accessOk, 1'b0);
    chk("R9 re-entry not yet asleep", sleepActive, 1'b0);
    step(2);
    chk("R9 asleep again", sleepActive, 1'b1);
    sleepReq = 1'b0;
    step(5);
    chk("R9 final wake", accessOk, 1'b1);
    chk("R9 no error", errFlag, 1'b0);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_enter();
    t_asleepIgnore();
    t_exit();
    t_awakeSelect();
    t_entryErr();
    t_recoveryErr();
    t_shortPulse();
    t_reRequest();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule